// File: doc/BRIEF.md
# NAND Single-Error-Correcting Parity Engine

This block builds a 24-bit Hamming-style check code over a fixed chunk of 512 bytes while the bytes stream past it. Every data bit in the chunk has a 12-bit address equal to its byte index times 8 plus its bit index. Each bit of the code's upper half is the parity of the data bits whose address has that bit set. Each bit of the lower half is the parity of the data bits whose address has that bit clear. The whole code is inverted, so a fully erased chunk (every byte 0xFF) yields 0xFFFFFF. That value matches what an erased spare area holds.

A host pulses `start_i` to open a chunk and offers bytes with `byte_valid_i`. Gaps between valid bytes are allowed. After the last byte the engine stops and raises `done_o`. The host supplies the code that was stored with the data on `stored_code_i`. The engine then classifies the difference between the stored code and the computed one:
- clean
- a single data bit flipped, with its byte and bit location
- a single bit flipped in the stored code itself
- uncorrectable

Pulsing `read_i` after the result has been taken clears the engine for the next chunk.

Top module: `nand_hamming_ecc`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0 and `code_o` is 0xFFFFFF.
- R2: A `start_i` pulse clears the accumulated code to 0xFFFFFF, clears `done_o`, sets `busy_o` and restarts at byte index 0. A byte offered in the same cycle is ignored, and a pulse while busy abandons the partial chunk.
- R3: A byte offered while `busy_o` is 0 leaves `code_o` and `done_o` unchanged.
- R4: `done_o` rises and `busy_o` falls in the cycle after the 512th accepted byte. Cycles without `byte_valid_i` do not advance the byte index.
- R5: `code_o[23:12]` is the bitwise inverse of the XOR of the 12-bit addresses of all set data bits. `code_o[11:0]` is the inverse of the XOR of the complements of those addresses.
- R6: A chunk of 512 bytes of 0xFF produces `code_o` = 0xFFFFFF.
- R7: With d = `stored_code_i` XOR `code_o`, `status_o` is 0 (clean) when d is zero.
- R8: `status_o` is 1 (data bit) when d[23:12] XOR d[11:0] equals 0xFFF and d[23:15] is below 512. In that case `err_byte_o` = d[23:15] and `err_bit_o` = d[14:12].
- R9: `status_o` is 2 (stored code bit) when exactly one bit of d is set.
- R10: `status_o` is 3 (uncorrectable) for any other nonzero d. `err_byte_o` and `err_bit_o` are 0 whenever `status_o` is not 1.
- R11: A `read_i` pulse without `start_i` returns `code_o` to 0xFFFFFF and clears `done_o` and `busy_o`. When both pulse in the same cycle, `start_i` takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Open a new chunk |
| read_i | input | 1 | Result taken; clear the engine |
| byte_valid_i | input | 1 | `byte_i` holds a chunk byte this cycle |
| byte_i | input | 8 | Chunk data byte |
| stored_code_i | input | 24 | Code read back with the data |
| busy_o | output | 1 | Chunk accumulation in progress |
| done_o | output | 1 | Whole chunk accumulated |
| code_o | output | 24 | Inverted packed check code |
| status_o | output | 2 | 0 clean, 1 data bit, 2 code bit, 3 uncorrectable |
| err_byte_o | output | 9 | Byte index of the flipped data bit |
| err_bit_o | output | 3 | Bit index of the flipped data bit |

## Verification
The hardest case to reach from the ports is a correctable error whose location lies at either end of the address space: bit 0 of byte 0, or bit 7 of byte 511. Random data seldom lands a flip there. The bench therefore builds a stored code from a bench model of the unmodified chunk. It then streams the chunk with one chosen bit flipped, including both end locations and random middle ones. It also streams two flipped bits to force the uncorrectable result, and flips single code bits for the stored-code case.

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc #(
  parameter int CHUNK_BYTES = 512,
  localparam int CNT_W  = $clog2(CHUNK_BYTES),
  localparam int ADDR_W = CNT_W + 3,
  localparam int CODE_W = 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              read_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic [CODE_W-1:0] stored_code_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CODE_W-1:0] code_o,
  output logic [1:0]        status_o,
  output logic [CNT_W-1:0]  err_byte_o,
  output logic [2:0]        err_bit_o
);

  logic [ADDR_W-1:0] set_par_q, clr_par_q, set_par_n, clr_par_n;
  logic [CNT_W-1:0]  cnt_q;
  logic              active_q, done_q;
  logic              take;

  assign take = active_q && byte_valid_i && !start_i && !read_i;

  always_comb begin
    set_par_n = set_par_q;
    clr_par_n = clr_par_q;
    for (int b = 0; b < 8; b++) begin
      if (byte_i[b]) begin
        set_par_n = set_par_n ^ {cnt_q, 3'(b)};
        clr_par_n = clr_par_n ^ ~{cnt_q, 3'(b)};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_par_q <= '0;
      clr_par_q <= '0;
      cnt_q     <= '0;
      active_q  <= 1'b0;
      done_q    <= 1'b0;
    end else if (start_i || read_i) begin
      set_par_q <= '0;
      clr_par_q <= '0;
      cnt_q     <= '0;
      active_q  <= start_i;
      done_q    <= 1'b0;
    end else if (take) begin
      set_par_q <= set_par_n;
      clr_par_q <= clr_par_n;
      if (cnt_q == CNT_W'(CHUNK_BYTES - 1)) begin
        cnt_q    <= '0;
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = active_q;
  assign done_o = done_q;
  assign code_o = ~{set_par_q, clr_par_q};

  logic [CODE_W-1:0] diff;
  logic [ADDR_W-1:0] hi_d, lo_d;
  logic [CNT_W-1:0]  loc_byte;
  logic              fixable;

  assign diff     = stored_code_i ^ code_o;
  assign hi_d     = diff[CODE_W-1:ADDR_W];
  assign lo_d     = diff[ADDR_W-1:0];
  assign loc_byte = hi_d[ADDR_W-1:3];
  assign fixable  = ((hi_d ^ lo_d) == '1) && (int'(loc_byte) < CHUNK_BYTES);

  always_comb begin
    status_o   = 2'd3;
    err_byte_o = '0;
    err_bit_o  = '0;
    if (diff == '0) begin
      status_o = 2'd0;
    end else if (fixable) begin
      status_o   = 2'd1;
      err_byte_o = loc_byte;
      err_bit_o  = hi_d[2:0];
    end else if ($onehot(diff)) begin
      status_o = 2'd2;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !busy_o && !done_o);

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o && !done_o && (code_o == '1));

  a_r3_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start_i && !read_i |=> $stable(code_o) && $stable(done_o));

  a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(busy_o) && $past(byte_valid_i) && !busy_o);

  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  a_r10_loc_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_o != 2'd1 |-> err_byte_o == '0 && err_bit_o == '0);

  a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    read_i && !start_i |=> !busy_o && !done_o && (code_o == '1));

endmodule

// File: tb/nand_hamming_ecc_test.sv
module nand_hamming_ecc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, read_i = 1'b0, byte_valid_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic [23:0] stored_code_i = '0;
  logic        busy_o, done_o;
  logic [23:0] code_o;
  logic [1:0]  status_o;
  logic [8:0]  err_byte_o;
  logic [2:0]  err_bit_o;

  int checks = 0, errors = 0;
  logic [7:0] mem [512];

  nand_hamming_ecc uut (.*);

  always #2 clk = ~clk;

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: expired, actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [23:0] model_code();
    logic [11:0] s = '0, c = '0;
    for (int i = 0; i < 512; i++)
      for (int b = 0; b < 8; b++)
        if (mem[i][b]) begin
          s ^= 12'(i * 8 + b);
          c ^= ~12'(i * 8 + b);
        end
    return ~{s, c};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1; byte_valid_i = 1'b1; byte_i = 8'h5A;
    @(negedge clk); start_i = 1'b0; byte_valid_i = 1'b0;
  endtask

  task automatic pulse_read();
    @(negedge clk); read_i = 1'b1;
    @(negedge clk); read_i = 1'b0;
  endtask

  task automatic stream(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gaps) begin
        while ($urandom_range(0, 3) == 0) begin
          byte_valid_i = 1'b0;
          @(negedge clk);
        end
      end
      byte_valid_i = 1'b1;
      byte_i = mem[i];
    end
    @(negedge clk);
    byte_valid_i = 1'b0;
  endtask

  task automatic fill_random();
    for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
  endtask

  task automatic flip_case(input int fb, input int fbit);
    logic [23:0] good;
    good = model_code();
    mem[fb][fbit] = ~mem[fb][fbit];
    pulse_start();
    stream(512, 1'b1);
    stored_code_i = good;
    #1;
    chk("R8 status", status_o, 2'd1);
    chk("R8 byte", err_byte_o, fb);
    chk("R8 bit", err_bit_o, fbit);
    mem[fb][fbit] = ~mem[fb][fbit];
    pulse_read();
  endtask

  initial begin
    logic [23:0] good;
    void'($urandom(32'd1234));
    #1;
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 code", code_o, 24'hFFFFFF);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 code after release", code_o, 24'hFFFFFF);

    // R6 erased chunk
    for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
    pulse_start();
    chk("R2 busy after start", busy_o, 1);
    stream(512, 1'b0);
    chk("R6 erased code", code_o, 24'hFFFFFF);
    stored_code_i = 24'hFFFFFF; #1;
    chk("R7 erased clean", status_o, 0);
    pulse_read();

    // R4 done timing
    fill_random();
    pulse_start();
    stream(511, 1'b1);
    chk("R4 not done at 511", done_o, 0);
    chk("R4 busy at 511", busy_o, 1);
    @(negedge clk); byte_valid_i = 1'b1; byte_i = mem[511];
    @(negedge clk); byte_valid_i = 1'b0;
    chk("R4 done after 512", done_o, 1);
    chk("R4 busy after 512", busy_o, 0);
    chk("R5 code", code_o, model_code());
    good = code_o;

    // R3 idle bytes ignored
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); byte_valid_i = 1'b1; byte_i = 8'($urandom);
    end
    @(negedge clk); byte_valid_i = 1'b0;
    chk("R3 code unchanged", code_o, good);
    chk("R3 done unchanged", done_o, 1);

    // R11 read clears
    pulse_read();
    chk("R11 code", code_o, 24'hFFFFFF);
    chk("R11 done", done_o, 0);
    chk("R11 busy", busy_o, 0);
    @(negedge clk); byte_valid_i = 1'b1; byte_i = 8'h01;
    @(negedge clk); byte_valid_i = 1'b0;
    chk("R3 idle after read", code_o, 24'hFFFFFF);

    // R11 start wins over read
    @(negedge clk); read_i = 1'b1; start_i = 1'b1;
    @(negedge clk); read_i = 1'b0; start_i = 1'b0;
    chk("R11 start priority", busy_o, 1);

    // R2 restart mid-chunk
    fill_random();
    stream(100, 1'b0);
    fill_random();
    pulse_start();
    stream(512, 1'b1);
    chk("R2 restart code", code_o, model_code());
    pulse_read();

    // R5 random chunks
    for (int t = 0; t < 6; t++) begin
      fill_random();
      pulse_start();
      stream(512, 1'b1);
      chk("R5 random code", code_o, model_code());
      stored_code_i = model_code(); #1;
      chk("R7 clean", status_o, 0);
      chk("R10 loc zero", {err_byte_o, err_bit_o}, 0);
      pulse_read();
    end

    // R8 correctable flips at ends and random
    fill_random();
    flip_case(0, 0);
    flip_case(511, 7);
    for (int t = 0; t < 5; t++) flip_case($urandom_range(0, 511), $urandom_range(0, 7));

    // R9 single stored-code bit
    fill_random();
    pulse_start();
    stream(512, 1'b0);
    good = code_o;
    for (int k = 0; k < 24; k += 5) begin
      stored_code_i = good ^ (24'h1 << k); #1;
      chk("R9 code bit", status_o, 2);
      chk("R10 loc zero on code bit", {err_byte_o, err_bit_o}, 0);
    end
    pulse_read();

    // R10 double data flip
    fill_random();
    good = model_code();
    mem[3][1] = ~mem[3][1];
    mem[400][6] = ~mem[400][6];
    pulse_start();
    stream(512, 1'b1);
    stored_code_i = good; #1;
    chk("R10 uncorrectable", status_o, 3);
    chk("R10 loc zero", {err_byte_o, err_bit_o}, 0);
    pulse_read();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule